// File: doc/BRIEF.md
# Handshaked Command/Response Byte Engine

This block is the device side of a byte-at-a-time command link between a host processor and a power-management controller. The host announces each byte by pulling a request line low. The device answers by pulling an acknowledge line low, and it lets that line go once the host has released its request. Bytes cross through an 8-bit shift-register interface. A direction bit owned by the host says whether the host is writing a byte to the device or reading one from it. Each byte that the engine accepts produces a single-cycle shift-complete interrupt.

A transaction starts with a command code. An internal table gives, for each code, the number of argument bytes and the number of response bytes. Either number may be marked variable. A variable argument count arrives as the byte right after the code. A variable response count goes out as the first byte the host reads. Once all arguments are in, the engine offers the command to an executor over a valid/ready handshake. `exec_valid` stays high with a stable code until `exec_ready` is seen. After that the executor returns the result as a byte stream on `res_*`. `res_ready` is high throughout the collect phase, so one beat is accepted per cycle and the executor must hold a beat until it sees `res_ready`. A beat with `res_none` carries no data. A single beat with `res_unknown` marks a code the executor does not know. While the executor works, host byte requests are not acknowledged. That stall is the only back-pressure the host sees. Background polling elsewhere is told to pause, through `poll_hold`, for the whole transaction.

Top module: `pmgr_cmd_engine`

## Requirements
- R1: After reset the acknowledge bit (bit 3 of `dev_port`) is 1. `sr_irq`, `poll_hold`, `err_overflow` and `exec_valid` are 0.
- R2: The request line is bit 4 of `host_port`, and both lines are active low. Request low with acknowledge high is a new byte, and acknowledge falls at the next edge. Request high with acknowledge low is a release, and acknowledge returns high at the next edge. Request held low while acknowledge is low changes nothing and raises no interrupt.
- R3: Every accepted byte raises `sr_irq` for exactly one cycle, in the same cycle in which acknowledge is first seen low.
- R4: `host_dir_wr`=1 means the host writes, and it is required while idle and while receiving. `host_dir_wr`=0 means the host reads, and it is required while sending. On a wrong direction, acknowledge still toggles, but no interrupt is raised and the byte is dropped without any change of state.
- R5: Codes with fixed lengths use the table: 0x10 takes 1 argument and returns 0 bytes; 0x30 takes 4 and returns 0; 0x38 takes 0 and returns 4; 0x48 takes 0 and returns a variable count; 0xC0–0xCF take 0 and return 2. The executor sees the code, the argument count and the stored arguments.
- R6: For a variable argument count (code 0x20 and every code not listed in R5), the first byte after the code is the count. The arguments that follow are then gathered.
- R7: For a variable response count, the first byte read is the number of response bytes. The response bytes follow it.
- R8: For a fixed response count, exactly that many bytes are sent, and the engine then returns to idle.
- R9: If the executor reports an unknown code, a fixed response count is answered with that many 0x00 bytes, and a variable response count is answered with a size byte of 0.
- R10: `poll_hold` is high from the acceptance of the code until the last response byte has been sent.
- R11: An argument count above the 64-byte capacity, or a result longer than 64 bytes, sets `err_overflow`, which stays set until reset. Only the first 64 arguments are stored and later bytes overwrite none of them. The count still advances so that the transaction completes.
- R12: `exec_valid` stays high with a stable `exec_cmd` until `exec_ready`. While the command is executing or its result is being collected, host requests are not acknowledged.
- R13: Completion is checked after every byte. A code with no arguments is issued to the executor as soon as it arrives. A fixed response count of zero returns the engine to idle in the same cycle in which the last result beat is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_port | input | 8 | Host-written port value; bit 4 is the active-low request |
| dev_port | output | 8 | Port read-back; bit 3 is the active-low acknowledge |
| host_dir_wr | input | 1 | 1: host writes the shift register, 0: host reads it |
| sr_wr_data | input | 8 | Byte written by the host |
| sr_rd_data | output | 8 | Byte offered to the host |
| sr_irq | output | 1 | One-cycle shift-complete pulse |
| exec_valid | output | 1 | Command ready for the executor |
| exec_ready | input | 1 | Executor accepts the command |
| exec_cmd | output | 8 | Command code |
| exec_arg_cnt | output | 8 | Argument count |
| exec_arg_idx | input | 6 | Argument read index |
| exec_arg_byte | output | 8 | Argument at `exec_arg_idx` |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat accepted |
| res_data | input | 8 | Result byte |
| res_none | input | 1 | Beat carries no data |
| res_unknown | input | 1 | Executor does not know the code |
| res_last | input | 1 | Final result beat |
| poll_hold | output | 1 | Pause background polling |
| err_overflow | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can fall into the same cycle. In the first, the last argument byte is acknowledged and interrupted while the command is issued to the executor. A command with no arguments takes this to its extreme, because the code byte alone triggers the dispatch. It is judged by checking that the interrupt appears while the executor already sees `exec_valid`, and that a host read issued at once is stalled until the result is in. In the second, a fixed zero-length response completes the result collection and the return to idle on one edge. This is provoked with code 0x10 and judged by `poll_hold` being low in the cycle after the final result beat.

// File: rtl/pmgr_pkg.sv
package pmgr_pkg;
  localparam int REQ_BIT = 4;
  localparam int ACK_BIT = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RECV    = 3'd1,
    ST_EXEC    = 3'd2,
    ST_COLLECT = 3'd3,
    ST_SEND    = 3'd4
  } eng_state_t;

  typedef struct packed {
    logic       var_len;
    logic [7:0] len;
  } len_spec_t;
endpackage

// File: rtl/pmgr_len_table.sv
module pmgr_len_table
  import pmgr_pkg::*;
(
  input  logic [7:0] code,
  output len_spec_t  arg_spec,
  output len_spec_t  rsp_spec
);
  always_comb begin
    arg_spec = '{var_len: 1'b1, len: 8'd0};
    rsp_spec = '{var_len: 1'b1, len: 8'd0};
    case (code)
      8'h10: begin
        arg_spec = '{var_len: 1'b0, len: 8'd1};
        rsp_spec = '{var_len: 1'b0, len: 8'd0};
      end
      8'h30: begin
        arg_spec = '{var_len: 1'b0, len: 8'd4};
        rsp_spec = '{var_len: 1'b0, len: 8'd0};
      end
      8'h38: begin
        arg_spec = '{var_len: 1'b0, len: 8'd0};
        rsp_spec = '{var_len: 1'b0, len: 8'd4};
      end
      8'h48: begin
        arg_spec = '{var_len: 1'b0, len: 8'd0};
      end
      default: begin
        if (code[7:4] == 4'hC) begin
          arg_spec = '{var_len: 1'b0, len: 8'd0};
          rsp_spec = '{var_len: 1'b0, len: 8'd2};
        end
      end
    endcase
  end
endmodule

// File: rtl/pmgr_byte_buf.sv
module pmgr_byte_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pmgr_hs_ctrl.sv
module pmgr_hs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic busy,
  output logic ack_n,
  output logic take
);
  assign take = !req_n && ack_n && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)              ack_n <= 1'b1;
    else if (take)           ack_n <= 1'b0;
    else if (req_n && !ack_n) ack_n <= 1'b1;
  end

  // R2: a release is answered on the next edge
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n && !ack_n) |=> ack_n);
  // R2: request held low after acknowledge changes nothing
  a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !ack_n) |=> !ack_n);
endmodule

// File: rtl/pmgr_cmd_engine.sv
module pmgr_cmd_engine
  import pmgr_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int AW = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    host_port,
  output logic [7:0]    dev_port,
  input  logic          host_dir_wr,
  input  logic [7:0]    sr_wr_data,
  output logic [7:0]    sr_rd_data,
  output logic          sr_irq,
  output logic          exec_valid,
  input  logic          exec_ready,
  output logic [7:0]    exec_cmd,
  output logic [7:0]    exec_arg_cnt,
  input  logic [AW-1:0] exec_arg_idx,
  output logic [7:0]    exec_arg_byte,
  input  logic          res_valid,
  output logic          res_ready,
  input  logic [7:0]    res_data,
  input  logic          res_none,
  input  logic          res_unknown,
  input  logic          res_last,
  output logic          poll_hold,
  output logic          err_overflow
);
  localparam logic [8:0] DEPTH9 = 9'(BUF_DEPTH);

  eng_state_t st;
  logic [7:0] cmd_q, apos, rpos, rsize, sr_out;
  len_spec_t  a_spec, r_spec, tbl_a, tbl_r;
  logic       zfill, irq_q, err_q;
  logic       ack_n, take, busy, wrong_dir, ok_take;
  logic [7:0] apos_inc, rpos_inc, cnt_next, fin_size, rsp_rd;
  logic       beat_data, rsp_zero, arg_wr;

  pmgr_len_table u_tbl (
    .code     (sr_wr_data),
    .arg_spec (tbl_a),
    .rsp_spec (tbl_r)
  );

  assign busy = (st == ST_EXEC) || (st == ST_COLLECT);

  pmgr_hs_ctrl u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .req_n (host_port[REQ_BIT]),
    .busy  (busy),
    .ack_n (ack_n),
    .take  (take)
  );

  assign wrong_dir = (st == ST_SEND) ? host_dir_wr : !host_dir_wr;
  assign ok_take   = take && !wrong_dir;
  assign apos_inc  = apos + 8'd1;
  assign rpos_inc  = rpos + 8'd1;

  assign arg_wr = ok_take && (st == ST_RECV) && !a_spec.var_len &&
                  ({1'b0, apos} < DEPTH9);

  pmgr_byte_buf #(.DEPTH(BUF_DEPTH)) u_argbuf (
    .clk     (clk),
    .wr_en   (arg_wr),
    .wr_addr (apos[AW-1:0]),
    .wr_data (sr_wr_data),
    .rd_addr (exec_arg_idx),
    .rd_data (exec_arg_byte)
  );

  assign beat_data = res_valid && !res_none && !res_unknown;
  assign cnt_next  = beat_data ? ((rsize == 8'hFF) ? rsize : rsize + 8'd1) : rsize;
  assign fin_size  = res_unknown ? (r_spec.var_len ? 8'd0 : r_spec.len) : cnt_next;

  pmgr_byte_buf #(.DEPTH(BUF_DEPTH)) u_rspbuf (
    .clk     (clk),
    .wr_en   ((st == ST_COLLECT) && beat_data && ({1'b0, rsize} < DEPTH9)),
    .wr_addr (rsize[AW-1:0]),
    .wr_data (res_data),
    .rd_addr (rpos[AW-1:0]),
    .rd_data (rsp_rd)
  );

  assign rsp_zero = zfill || (rpos >= rsize) || ({1'b0, rpos} >= DEPTH9);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cmd_q  <= 8'd0;
      a_spec <= '0;
      r_spec <= '0;
      apos   <= 8'd0;
      rpos   <= 8'd0;
      rsize  <= 8'd0;
      sr_out <= 8'd0;
      zfill  <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st)
        ST_IDLE: if (ok_take) begin
          irq_q  <= 1'b1;
          cmd_q  <= sr_wr_data;
          a_spec <= tbl_a;
          r_spec <= tbl_r;
          apos   <= 8'd0;
          rpos   <= 8'd0;
          zfill  <= 1'b0;
          st     <= (!tbl_a.var_len && tbl_a.len == 8'd0) ? ST_EXEC : ST_RECV;
        end
        ST_RECV: if (ok_take) begin
          irq_q <= 1'b1;
          if (a_spec.var_len) begin
            a_spec <= '{var_len: 1'b0, len: sr_wr_data};
            if ({1'b0, sr_wr_data} > DEPTH9) err_q <= 1'b1;
            if (sr_wr_data == 8'd0) st <= ST_EXEC;
          end else begin
            apos <= apos_inc;
            if (apos_inc == a_spec.len) st <= ST_EXEC;
          end
        end
        ST_EXEC: if (exec_ready) begin
          st    <= ST_COLLECT;
          rsize <= 8'd0;
        end
        ST_COLLECT: if (res_valid) begin
          if (beat_data && !({1'b0, rsize} < DEPTH9)) err_q <= 1'b1;
          if (res_unknown) zfill <= 1'b1;
          if (res_last) begin
            rsize <= fin_size;
            st    <= (!r_spec.var_len && r_spec.len == 8'd0) ? ST_IDLE : ST_SEND;
          end else begin
            rsize <= cnt_next;
          end
        end
        ST_SEND: if (ok_take) begin
          irq_q <= 1'b1;
          if (r_spec.var_len) begin
            sr_out <= rsize;
            r_spec <= '{var_len: 1'b0, len: rsize};
            if (rsize == 8'd0) st <= ST_IDLE;
          end else begin
            sr_out <= rsp_zero ? 8'd0 : rsp_rd;
            rpos   <= rpos_inc;
            if (rpos_inc == r_spec.len) st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dev_port          = host_port;
    dev_port[ACK_BIT] = ack_n;
  end

  assign sr_rd_data   = sr_out;
  assign sr_irq       = irq_q;
  assign exec_valid   = (st == ST_EXEC);
  assign exec_cmd     = cmd_q;
  assign exec_arg_cnt = a_spec.len;
  assign res_ready    = (st == ST_COLLECT);
  assign poll_hold    = (st != ST_IDLE);
  assign err_overflow = err_q;

  // R3: interrupt is a single-cycle pulse
  a_r3_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);
  // R4: a byte with the wrong direction raises no interrupt
  a_r4_wrong_dir_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wrong_dir) |=> !sr_irq);
  // R12: command offer is held stable until accepted
  a_r12_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !exec_ready) |=> (exec_valid && $stable(exec_cmd)));
  // R12: no acknowledge while executing or collecting
  a_r12_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ack_n) |=> ack_n);
  // R11: overflow flag is sticky
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
endmodule

// File: tb/sim_pmgr_cmd_engine.sv
`timescale 1ns/1ps
module sim_pmgr_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_port = 8'hFF;
  logic [7:0] dev_port;
  logic       host_dir_wr = 1'b1;
  logic [7:0] sr_wr_data = 8'd0;
  logic [7:0] sr_rd_data;
  logic       sr_irq;
  logic       exec_valid;
  logic       exec_ready = 1'b0;
  logic [7:0] exec_cmd, exec_arg_cnt, exec_arg_byte;
  logic [5:0] exec_arg_idx = 6'd0;
  logic       res_valid = 1'b0, res_none = 1'b0, res_unknown = 1'b0, res_last = 1'b0;
  logic [7:0] res_data = 8'd0;
  logic       res_ready, poll_hold, err_overflow;

  int total = 0, bad = 0, exec_count = 0;
  logic [7:0] expq[$];
  logic [7:0] exp_args [256];
  int exp_cnt = 0;
  logic [7:0] exp_cmd = 8'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmgr_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .host_port(host_port), .dev_port(dev_port),
    .host_dir_wr(host_dir_wr), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
    .sr_irq(sr_irq), .exec_valid(exec_valid), .exec_ready(exec_ready),
    .exec_cmd(exec_cmd), .exec_arg_cnt(exec_arg_cnt), .exec_arg_idx(exec_arg_idx),
    .exec_arg_byte(exec_arg_byte), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_none(res_none), .res_unknown(res_unknown),
    .res_last(res_last), .poll_hold(poll_hold), .err_overflow(err_overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: every read byte is compared against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && sr_irq && !host_dir_wr) begin
      if (expq.size() == 0) chk(1'b0, "R7/R8 unexpected byte", sr_rd_data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(sr_rd_data == e, "R7/R8 response byte", sr_rd_data, e);
      end
    end
  end

  task automatic xfer(input logic [7:0] b, input bit dir, input int hold);
    @(negedge clk);
    host_dir_wr = dir;
    sr_wr_data  = b;
    host_port[4] = 1'b0;
    do @(negedge clk); while (dev_port[3]);
    chk(sr_irq == 1'b1, "R3 irq with acknowledge", sr_irq, 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(dev_port[3] == 1'b0 && sr_irq == 1'b0, "R2 request held low", {dev_port[3], sr_irq}, 0);
    end
    host_port[4] = 1'b1;
    @(negedge clk);
    chk(dev_port[3] == 1'b1 && sr_irq == 1'b0, "R2/R3 release", {dev_port[3], sr_irq}, 2);
  endtask

  task automatic host_wr(input logic [7:0] b);
    xfer(b, 1'b1, 0);
  endtask

  task automatic host_rd();
    xfer(8'h00, 1'b0, 0);
  endtask

  task automatic host_bad(input logic [7:0] b, input bit dir);
    @(negedge clk);
    host_dir_wr = dir;
    sr_wr_data  = b;
    host_port[4] = 1'b0;
    do @(negedge clk); while (dev_port[3]);
    chk(sr_irq == 1'b0, "R4 no irq on wrong direction", sr_irq, 0);
    host_port[4] = 1'b1;
    @(negedge clk);
    chk(dev_port[3] == 1'b1, "R4 acknowledge released", dev_port[3], 1);
  endtask

  // executor model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && exec_valid) begin
        int nb, ncap, mism;
        bit stall_bad, drop;
        logic [7:0] bd [8];
        logic [7:0] c;
        stall_bad = 1'b0; drop = 1'b0; mism = 0;
        for (int k = 0; k < 5; k++) begin
          @(negedge clk);
          if (!exec_valid || exec_cmd != exp_cmd) drop = 1'b1;
          if (!host_port[4] && !dev_port[3]) stall_bad = 1'b1;
        end
        chk(!drop, "R12 exec_valid held with stable code", exec_valid, 1);
        chk(!stall_bad, "R12 host stalled while executing", stall_bad, 0);
        c = exec_cmd;
        chk(c == exp_cmd, "R5 executor code", c, exp_cmd);
        chk(exec_arg_cnt == 8'(exp_cnt), "R5/R6 argument count", exec_arg_cnt, exp_cnt);
        ncap = (exec_arg_cnt > 8'd64) ? 64 : int'(exec_arg_cnt);
        for (int i = 0; i < ncap; i++) begin
          exec_arg_idx = 6'(i);
          #0.1;
          bd[0] = exec_arg_byte;
          if (bd[0] != exp_args[i]) mism++;
          if (i < 4) bd[i+4] = exec_arg_byte;
        end
        chk(mism == 0, "R5/R6/R11 stored arguments", mism, 0);
        @(negedge clk);
        exec_ready = 1'b1;
        @(negedge clk);
        exec_ready = 1'b0;
        res_none = 1'b0; res_unknown = 1'b0;
        nb = 0;
        case (c)
          8'h38: begin bd[0]=8'hA1; bd[1]=8'hB2; bd[2]=8'hC3; bd[3]=8'hD4; nb=4; end
          8'h48: begin bd[0]=8'h11; bd[1]=8'h22; bd[2]=8'h33; nb=3; end
          8'h20: begin
            nb = (ncap > 4) ? 4 : ncap;
            for (int i = 0; i < 4; i++) bd[i] = bd[i+4] ^ 8'h5A;
          end
          8'h10, 8'h30: nb = 0;
          default: nb = -1;
        endcase
        if (nb <= 0) begin
          res_none = (nb == 0); res_unknown = (nb < 0);
          res_last = 1'b1; res_valid = 1'b1;
          @(negedge clk);
        end else begin
          for (int i = 0; i < nb; i++) begin
            res_data = bd[i]; res_last = (i == nb - 1); res_valid = 1'b1;
            @(negedge clk);
          end
        end
        res_valid = 1'b0; res_last = 1'b0; res_none = 1'b0; res_unknown = 1'b0;
        exec_count++;
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dev_port[3] == 1'b1, "R1 acknowledge idle high", dev_port[3], 1);
    chk(!sr_irq && !poll_hold && !err_overflow && !exec_valid, "R1 outputs low",
        {sr_irq, poll_hold, err_overflow, exec_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13/R8: zero-argument code, fixed four-byte response
    exp_cmd = 8'h38; exp_cnt = 0; n = exec_count;
    host_wr(8'h38);
    chk(poll_hold == 1'b1, "R10 hold after code", poll_hold, 1);
    expq.push_back(8'hA1); expq.push_back(8'hB2); expq.push_back(8'hC3); expq.push_back(8'hD4);
    for (int i = 0; i < 4; i++) host_rd();
    chk(poll_hold == 1'b0, "R8/R10 idle after fixed response", poll_hold, 0);
    chk(exec_count == n + 1, "R13 dispatched once", exec_count, n + 1);

    // R13: fixed zero response returns to idle with the last beat
    exp_cmd = 8'h10; exp_cnt = 1; exp_args[0] = 8'h5C; n = exec_count;
    host_wr(8'h10);
    host_wr(8'h5C);
    wait (exec_count == n + 1);
    chk(poll_hold == 1'b0, "R13 idle after zero-length result", poll_hold, 0);

    // R6/R7 variable argument and response, plus request hold (R2)
    exp_cmd = 8'h20; exp_cnt = 3;
    exp_args[0] = 8'h07; exp_args[1] = 8'h08; exp_args[2] = 8'h09;
    host_wr(8'h20);
    host_wr(8'h03);
    xfer(8'h07, 1'b1, 3);
    host_wr(8'h08);
    host_wr(8'h09);
    expq.push_back(8'h03); expq.push_back(8'h5D); expq.push_back(8'h52); expq.push_back(8'h53);
    for (int i = 0; i < 4; i++) host_rd();
    chk(poll_hold == 1'b0, "R7 idle after variable response", poll_hold, 0);

    // R4: wrong direction in idle and in send
    host_bad(8'h38, 1'b0);
    chk(poll_hold == 1'b0, "R4 idle unchanged", poll_hold, 0);
    exp_cmd = 8'h48; exp_cnt = 0;
    host_wr(8'h48);
    host_bad(8'h00, 1'b1);
    expq.push_back(8'h03); expq.push_back(8'h11); expq.push_back(8'h22); expq.push_back(8'h33);
    for (int i = 0; i < 4; i++) host_rd();
    chk(poll_hold == 1'b0, "R4 send resumed then idle", poll_hold, 0);

    // R9 unknown codes
    exp_cmd = 8'hC5; exp_cnt = 0;
    host_wr(8'hC5);
    expq.push_back(8'h00); expq.push_back(8'h00);
    host_rd(); host_rd();
    chk(poll_hold == 1'b0, "R9 fixed unknown zeros then idle", poll_hold, 0);
    exp_cmd = 8'h99; exp_cnt = 1; exp_args[0] = 8'hEE;
    host_wr(8'h99); host_wr(8'h01); host_wr(8'hEE);
    expq.push_back(8'h00);
    host_rd();
    chk(poll_hold == 1'b0, "R9 variable unknown size zero", poll_hold, 0);

    // R11 overflow
    chk(err_overflow == 1'b0, "R11 no error yet", err_overflow, 0);
    exp_cmd = 8'h20; exp_cnt = 70;
    for (int i = 0; i < 70; i++) exp_args[i] = 8'(i + 1);
    host_wr(8'h20); host_wr(8'd70);
    for (int i = 0; i < 70; i++) host_wr(8'(i + 1));
    expq.push_back(8'h04); expq.push_back(8'h5B); expq.push_back(8'h58);
    expq.push_back(8'h59); expq.push_back(8'h5E);
    for (int i = 0; i < 5; i++) host_rd();
    chk(err_overflow == 1'b1, "R11 overflow flagged", err_overflow, 1);
    exp_cmd = 8'h30; exp_cnt = 4;
    for (int i = 0; i < 4; i++) exp_args[i] = 8'(8'h40 + i);
    n = exec_count;
    host_wr(8'h30);
    for (int i = 0; i < 4; i++) host_wr(8'(8'h40 + i));
    wait (exec_count == n + 1);
    @(negedge clk);
    chk(err_overflow == 1'b1, "R11 flag sticky", err_overflow, 1);
    chk(poll_hold == 1'b0, "R5 fixed four-argument code done", poll_hold, 0);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R7/R8 all responses seen", expq.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule